// File: doc/BRIEF.md
# Shared ready/data serial output port

This block is the converter-side end of a two-wire serial link. A single output line does two jobs. It announces that a fresh conversion result is waiting, and it then carries that result MSB-first, clocked by the host's serial clock. The filter hands the block a 24-bit word together with a one-cycle load strobe. The block first holds the line high for a short load window. It then drives a low ready pulse followed by a high gap, and after that it presents the data bits. The data stays available until the next load strobe.

The host's serial clock is normally idle low. The block also watches for that clock being held high across whole conversion periods, timed by an internal period timer. After a few periods of high hold, the block gives one short low pulse on the line and then keeps the line high. It also raises a request that holds the modulator in reset, which is how several converters are aligned. If the hold continues for many more periods, the block raises a power-down flag. A falling edge on the serial clock releases both conditions. The next load strobe then yields a normal ready pulse with valid data.

Top module: `drdy_serial_port`

## Requirements
- R1: A load strobe accepted outside the held state captures `res_data`, resets the bit pointer to the MSB and holds `dout_rdy` high for `LOAD_CYC` cycles, starting with the cycle after the strobe edge.
- R2: After the load window, `dout_rdy` is low for `RDY_LO_CYC` cycles and then high for `RDY_HI_CYC` cycles. The block then enters data mode, where the line shows the current bit.
- R3: In data mode, each synchronised falling edge of `sclk` advances the pointer by one bit. After k falling edges (k < 24) the line shows bit 23-k of the captured word, where bit 23 is the MSB.
- R4: With no falling edges, the line keeps showing the current bit (the MSB, or the bit reached by a partial read) until the next load strobe.
- R5: Once 24 falling edges have arrived in data mode, the line is driven low until the next load strobe.
- R6: Falling edges of `sclk` during the load window or the ready pulse do not move the bit pointer.
- R7: When `sclk` has been seen high across `SYNC_PERIODS` period-timer ticks, the line goes low for exactly one system clock and then stays high, and `mod_reset` is 1 from that low cycle onward.
- R8: While `mod_reset` is 1, load strobes are ignored and the line stays high.
- R9: When the high hold reaches `PD_PERIODS` ticks in total, `pwr_down` rises exactly `(PD_PERIODS-SYNC_PERIODS)*PERIOD_CYC` cycles after `mod_reset` rose. `pwr_down` is never 1 without `mod_reset`.
- R10: A synchronised falling edge of `sclk` clears both `mod_reset` and `pwr_down` and leaves the line high. The next load strobe then produces the normal R1/R2 sequence with valid data.
- R11: The high-hold count clears on any synchronised low level of `sclk`, so separate high stretches shorter than `SYNC_PERIODS` periods never trigger a sync.
- R12: After reset, `dout_rdy` is 1, `mod_reset` is 0 and `pwr_down` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host serial clock, asynchronous to clk |
| res_data | input | 24 | New conversion result, two's complement |
| res_load | input | 1 | One-cycle strobe that presents a new result |
| dout_rdy | output | 1 | Combined ready pulse and serial data line |
| mod_reset | output | 1 | Request to hold the modulator in reset (sync state) |
| pwr_down | output | 1 | Power-down state flag |

## Verification
The bit pointer and the shift register each show up on the line within three system clocks of the host's falling edge. A stuck or miscounted pointer therefore shows a wrong bit on the very next sample, or a missing low level after the 24th edge. The phase counter shows up as a ready pulse that is misplaced or has the wrong length, visible in the first dozen cycles after a load. The hold counter can only be seen through `mod_reset` and `pwr_down`. The bench therefore brackets those edges against the period timer, one tick either side. A counter that fails to clear, or that stops at the wrong value, gives a sync or power-down entry that is early, late or missing.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_RDY_LO,
        PH_RDY_HI,
        PH_DATA,
        PH_SYNC_PULSE,
        PH_HOLD
    } phase_e;
endpackage

// File: rtl/sps_sclk_sync.sv
module sps_sclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    output logic sclk_s,
    output logic sclk_fall
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
        logic              prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], sclk_in};
        st_d.prev = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sclk_s    = st_q.pipe[STAGES-1];
    assign sclk_fall = st_q.prev & ~st_q.pipe[STAGES-1];
endmodule

// File: rtl/sps_hold_detect.sv
module sps_hold_detect #(
    parameter int PERIOD_CYC   = 384,
    parameter int SYNC_PERIODS = 4,
    parameter int PD_PERIODS   = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    output logic sync_req,
    output logic pd_req
);
    localparam int PW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
    localparam int HW = $clog2(PD_PERIODS + 1);

    typedef struct packed {
        logic [PW-1:0] per;
        logic [HW-1:0] hold;
    } st_t;

    st_t  st_d, st_q;
    logic tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.per == PW'(PERIOD_CYC - 1));
        if (tick) st_d.per = '0;
        else      st_d.per = st_q.per + PW'(1);
        if (!sclk_s)
            st_d.hold = '0;
        else if (tick && (st_q.hold != HW'(PD_PERIODS)))
            st_d.hold = st_q.hold + HW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_req = (st_q.hold >= HW'(SYNC_PERIODS));
    assign pd_req   = (st_q.hold == HW'(PD_PERIODS));
endmodule

// File: rtl/sps_shifter.sv
module sps_shifter #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift_en,
    output logic              bit_out
);
    localparam int CW = $clog2(DATA_W + 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [CW-1:0]     cnt;
    } st_t;

    st_t  st_d, st_q;
    logic spent;

    always_comb begin
        st_d  = st_q;
        spent = (st_q.cnt == CW'(DATA_W));
        if (load) begin
            st_d.sh  = load_data;
            st_d.cnt = '0;
        end else if (shift_en && !spent) begin
            st_d.sh  = {st_q.sh[DATA_W-2:0], 1'b0};
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_out = spent ? 1'b0 : st_q.sh[DATA_W-1];
endmodule

// File: rtl/drdy_serial_port.sv
module drdy_serial_port
    import sps_pkg::*;
#(
    parameter int DATA_W       = 24,
    parameter int LOAD_CYC     = 4,
    parameter int RDY_LO_CYC   = 2,
    parameter int RDY_HI_CYC   = 2,
    parameter int PERIOD_CYC   = 384,
    parameter int SYNC_PERIODS = 4,
    parameter int PD_PERIODS   = 20,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_load,
    output logic              dout_rdy,
    output logic              mod_reset,
    output logic              pwr_down
);
    localparam int WMAX_A = (LOAD_CYC > RDY_LO_CYC) ? LOAD_CYC : RDY_LO_CYC;
    localparam int WMAX   = (WMAX_A > RDY_HI_CYC) ? WMAX_A : RDY_HI_CYC;
    localparam int WW     = $clog2(WMAX + 1);

    typedef struct packed {
        phase_e        phase;
        logic [WW-1:0] win;
        logic          pd;
    } st_t;

    st_t  st_d, st_q;
    logic sclk_s, sclk_fall;
    logic sync_req, pd_req;
    logic load_go, shift_en, bit_out;

    sps_sclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk),
        .sclk_s(sclk_s), .sclk_fall(sclk_fall)
    );

    sps_hold_detect #(
        .PERIOD_CYC(PERIOD_CYC), .SYNC_PERIODS(SYNC_PERIODS), .PD_PERIODS(PD_PERIODS)
    ) u_hold (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s),
        .sync_req(sync_req), .pd_req(pd_req)
    );

    sps_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_go), .load_data(res_data),
        .shift_en(shift_en), .bit_out(bit_out)
    );

    always_comb begin
        st_d    = st_q;
        load_go = 1'b0;
        unique case (st_q.phase)
            PH_SYNC_PULSE: st_d.phase = PH_HOLD;
            PH_HOLD: begin
                if (sclk_fall) begin
                    st_d.phase = PH_IDLE;
                    st_d.pd    = 1'b0;
                end else if (pd_req) begin
                    st_d.pd = 1'b1;
                end
            end
            default: begin
                if (sync_req) begin
                    st_d.phase = PH_SYNC_PULSE;
                end else if (res_load) begin
                    load_go    = 1'b1;
                    st_d.phase = PH_LOAD;
                    st_d.win   = WW'(LOAD_CYC - 1);
                end else begin
                    case (st_q.phase)
                        PH_LOAD: begin
                            if (st_q.win == '0) begin
                                st_d.phase = PH_RDY_LO;
                                st_d.win   = WW'(RDY_LO_CYC - 1);
                            end else st_d.win = st_q.win - WW'(1);
                        end
                        PH_RDY_LO: begin
                            if (st_q.win == '0) begin
                                st_d.phase = PH_RDY_HI;
                                st_d.win   = WW'(RDY_HI_CYC - 1);
                            end else st_d.win = st_q.win - WW'(1);
                        end
                        PH_RDY_HI: begin
                            if (st_q.win == '0) st_d.phase = PH_DATA;
                            else                st_d.win   = st_q.win - WW'(1);
                        end
                        default: ;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.win   <= '0;
            st_q.pd    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_en = sclk_fall && (st_q.phase == PH_DATA);

    always_comb begin
        case (st_q.phase)
            PH_RDY_LO, PH_SYNC_PULSE: dout_rdy = 1'b0;
            PH_DATA:                  dout_rdy = bit_out;
            default:                  dout_rdy = 1'b1;
        endcase
    end

    assign mod_reset = (st_q.phase == PH_SYNC_PULSE) || (st_q.phase == PH_HOLD);
    assign pwr_down  = st_q.pd;
endmodule

// File: rtl/sps_checker.sv
module sps_checker (
    input logic clk,
    input logic rst_n,
    input logic res_load,
    input logic sclk_s,
    input logic sync_req,
    input logic dout_rdy,
    input logic mod_reset,
    input logic pwr_down
);
    // R1: an accepted load opens the window with the line high
    a_r1_load_window_high: assert property (@(posedge clk) disable iff (!rst_n)
        (res_load && !mod_reset && !sync_req) |=> dout_rdy);

    // R7: sync entry starts with a low cycle
    a_r7_sync_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_reset) |-> !dout_rdy);

    // R7 / R8: after the single low cycle the line stays high while held
    a_r8_held_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_reset && $past(mod_reset)) |-> dout_rdy);

    // R9: power-down only inside the held state
    a_r9_pd_needs_reset: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> mod_reset);

    // R9: power-down rises only after the hold was already in place
    a_r9_pd_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> $past(mod_reset));

    // R10: release only follows a low serial clock
    a_r10_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_reset) |-> !sclk_s);
endmodule

bind drdy_serial_port sps_checker u_chk (
    .clk(clk), .rst_n(rst_n), .res_load(res_load), .sclk_s(sclk_s),
    .sync_req(sync_req), .dout_rdy(dout_rdy), .mod_reset(mod_reset),
    .pwr_down(pwr_down)
);

// File: tb/sim_drdy_serial_port.sv
module sim_drdy_serial_port;
    localparam int DW  = 24;
    localparam int LD  = 6;
    localparam int LO  = 3;
    localparam int HI  = 3;
    localparam int P   = 16;
    localparam int SY  = 4;
    localparam int PD  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sclk = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic          res_load = 1'b0;
    logic          dout_rdy, mod_reset, pwr_down;

    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    drdy_serial_port #(
        .DATA_W(DW), .LOAD_CYC(LD), .RDY_LO_CYC(LO), .RDY_HI_CYC(HI),
        .PERIOD_CYC(P), .SYNC_PERIODS(SY), .PD_PERIODS(PD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .res_data(res_data),
        .res_load(res_load), .dout_rdy(dout_rdy), .mod_reset(mod_reset),
        .pwr_down(pwr_down)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic sclk_fall_edge();
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Loads a word, checks R1/R2 timing, then reads nbits bits (R3, R5).
    task automatic read_word(input logic [DW-1:0] data, input int nbits, input string tag);
        @(negedge clk);
        res_data = data;
        res_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        res_load = 1'b0;
        for (int c = 1; c <= LD + LO + HI; c++) begin
            if (c <= LD)           chk({tag, " R1 load window"}, dout_rdy, 1'b1);
            else if (c <= LD + LO) chk({tag, " R2 ready low"}, dout_rdy, 1'b0);
            else                   chk({tag, " R2 ready high"}, dout_rdy, 1'b1);
            @(negedge clk);
        end
        chk({tag, " R3 msb first"}, dout_rdy, data[DW-1]);
        for (int k = 1; k <= nbits; k++) begin
            sclk_fall_edge();
            if (k < DW) chk({tag, " R3 bit"}, dout_rdy, data[DW-1-k]);
            else        chk({tag, " R5 overrun low"}, dout_rdy, 1'b0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int lows;
        int since;
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset line", dout_rdy, 1'b1);
        chk("R12 reset mod_reset", mod_reset, 1'b0);
        chk("R12 reset pwr_down", pwr_down, 1'b0);

        // R11: two high stretches split by a low level never sync
        lows = 0;
        sclk = 1'b1;
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (!dout_rdy) lows++;
        end
        chk("R11 first stretch", mod_reset, 1'b0);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        sclk = 1'b1;
        for (int i = 0; i < 3 * P; i++) begin
            @(negedge clk);
            if (!dout_rdy) lows++;
        end
        chk("R11 second stretch", mod_reset, 1'b0);

        // R7: continue the hold until sync entry
        seen = 1'b0;
        since = 0;
        for (int i = 0; i < P + 8; i++) begin
            @(negedge clk);
            if (!dout_rdy) lows++;
            if (seen) since++;
            if (mod_reset && !seen) begin
                seen = 1'b1;
                chk("R7 low on entry", dout_rdy, 1'b0);
            end
        end
        chk("R7 mod_reset set", mod_reset, 1'b1);
        chk("R7 single low cycle", (lows == 1), 1'b1);

        // R8: load strobe while held is ignored
        @(negedge clk);
        since++;
        res_data = '0;
        res_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        since++;
        res_load = 1'b0;
        for (int i = 0; i < 20; i++) begin
            chk("R8 line stays high", dout_rdy, 1'b1);
            @(negedge clk);
            since++;
        end

        // R9: power-down timing relative to sync entry
        while (since < (PD - SY) * P - 2) begin
            @(negedge clk);
            since++;
        end
        chk("R9 no early power-down", pwr_down, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9 power-down set", pwr_down, 1'b1);
        chk("R9 still held", mod_reset, 1'b1);

        // R10: release on falling edge, then a valid read
        sclk = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 mod_reset cleared", mod_reset, 1'b0);
        chk("R10 pwr_down cleared", pwr_down, 1'b0);
        chk("R10 line high", dout_rdy, 1'b1);
        read_word(24'hC3A501, 24, "R10 after release");

        // R3 / R5 sweep: walking one and walking zero over every position
        for (int b = 0; b < DW; b++) begin
            read_word(24'h000001 << b, DW + 1, "sweep one");
            read_word(~(24'h000001 << b), DW + 1, "sweep zero");
        end
        read_word(24'h5A5A5A, DW + 3, "pattern");
        read_word(24'h800000, DW + 2, "negative full scale");
        read_word(24'h7FFFFF, DW + 2, "positive full scale");

        // R4: no clock holds the MSB; partial read holds its bit
        read_word(24'hA00000, 0, "R4 idle msb");
        repeat (60) @(negedge clk);
        chk("R4 msb held", dout_rdy, 1'b1);
        read_word(24'h3C00F0, 5, "R4 partial");
        repeat (60) @(negedge clk);
        chk("R4 partial bit held", dout_rdy, 1'b1);

        // R5: overrun low persists, then the next load restarts at MSB
        read_word(24'hFFFFFF, DW, "R5 overrun");
        repeat (40) @(negedge clk);
        chk("R5 low persists", dout_rdy, 1'b0);
        read_word(24'hFFFFFF, 1, "R5 next load");

        // R6: a falling edge in the load window does not move the pointer
        @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        res_data = 24'h800000;
        res_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        res_load = 1'b0;
        sclk = 1'b0;
        repeat (LD + LO + HI) @(negedge clk);
        chk("R6 pointer unchanged", dout_rdy, 1'b1);
        sclk_fall_edge();
        chk("R6 next bit after edge", dout_rdy, 1'b0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule